// File: doc/BRIEF.md
# Channel-Interleaved Multichannel FIR Filter

This block runs several independent FIR filters through one shared fully parallel multiply-accumulate datapath. Samples for K channels arrive one at a time on a scalar input. Each valid cycle carries the next channel in a fixed rotation: channel 0, then 1, up to K-1, and then channel 0 again. The block keeps a separate delay line for each channel. On each accepted sample it applies that channel's own row of a K-by-L coefficient table, which is fixed by parameter. Every accepted sample produces exactly one output, flagged valid, and outputs leave in the same channel order as the inputs.

The full-precision accumulator has width DW + CW + ceil(log2(L)). The output is a parameterised bit slice of that accumulator. An elaboration option folds the taps when every channel's row is even-symmetric: mirrored samples are pre-added so that only ceil(L/2) multipliers are built. Zero-valued coefficients are never pruned, so one datapath serves every channel row. An asynchronous active-low reset and a synchronous clear input both empty all channel state and drop results that are still in flight.

Top module: `mcfir_top`

## Requirements
- R1: A channel counter starts at 0 after reset or clear and advances by one on each accepted sample (in_vld high, clr low), wrapping from NCH-1 to 0. The accepted sample is filtered with coefficient row `COEFS[(ch*NTAP+k)*CW +: CW]` for tap k, where ch is the counter value.
- R2: Each channel has its own delay line. For channel ch the result is sum over k of coef(ch,k) times the k-th most recent sample of that channel (k=0 is the current sample). Samples of other channels never enter it, and missing history counts as zero.
- R3: A cycle with in_vld low changes no state and produces no output, whatever in_dat holds.
- R4: out_vld is high exactly two clock cycles after an accepted sample, and only then, so there is one output per accepted sample and the order is preserved.
- R5: Products and their sum are held at full precision in DW+CW+ceil(log2(NTAP)) signed bits. out_dat equals bits [OUT_LSB +: OW] of that sum, with no rounding or saturation.
- R6: A cycle with clr high clears every delay line, returns the channel counter to 0 and suppresses the results of samples accepted in that cycle or the cycle before. The sample presented with clr is not accepted.
- R7: While rst_n is low, out_vld and out_dat are 0 at once, without waiting for a clock edge. After release, all channels start from empty history at channel 0.
- R8: With FOLD set to even-symmetric and symmetric coefficient rows, the outputs equal those of the unfolded direct form for the same rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all filter state |
| in_vld | input | 1 | Input sample valid |
| in_dat | input | DW | Signed input sample of the current channel |
| out_vld | output | 1 | Output sample valid |
| out_dat | output | OW | Signed output slice of the full-precision sum |

## Verification
A sample accepted at one rising edge is multiplied into the first pipeline register at that edge. It is summed into the output register at the next edge, so out_vld and out_dat are due right after the second edge. The bench drives each input just after a falling edge and samples 1 ns after the following rising edge. It compares what it sees against the expectation the model made one step earlier, which is exactly that two-edge distance. A clear voids both the result due at its own edge and the one after it. An asynchronous reset is checked a few nanoseconds after assertion, between edges.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;

  // Tap folding variant selected at elaboration.
  typedef enum logic {
    TAPS_DIRECT   = 1'b0,
    TAPS_EVEN_SYM = 1'b1
  } fold_e;

  // Full-precision accumulator width for ntap products of dw x cw bits.
  function automatic int acc_bits(int dw, int cw, int ntap);
    return dw + cw + $clog2(ntap);
  endfunction

endpackage

// File: rtl/mcfir_chan_ctr.sv
module mcfir_chan_ctr #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  output logic [CHW-1:0] chan
);

  logic [CHW-1:0] chan_d;
  logic           chan_en;

  assign chan_en = clr | adv;

  always_comb begin
    chan_d = chan;
    if (clr) begin
      chan_d = '0;
    end else if (adv) begin
      chan_d = (chan == CHW'(NCH - 1)) ? '0 : chan + CHW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0;
    end else if (chan_en) begin
      chan <= chan_d;
    end
  end

endmodule

// File: rtl/mcfir_delay_bank.sv
module mcfir_delay_bank #(
  parameter int NCH  = 3,
  parameter int NTAP = 4,
  parameter int DW   = 8,
  parameter int CHW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      adv,
  input  logic [CHW-1:0]            chan,
  input  logic [DW-1:0]             din,
  output logic [NTAP-1:0][DW-1:0]   taps
);

  localparam int DEP = NTAP - 1;

  logic [NCH-1:0][DEP-1:0][DW-1:0] line_q;
  logic [NCH-1:0][DEP-1:0][DW-1:0] line_d;
  logic                            line_en;

  assign line_en = clr | adv;

  always_comb begin
    line_d = line_q;
    if (clr) begin
      line_d = '0;
    end else if (adv) begin
      for (int k = DEP - 1; k > 0; k--) begin
        line_d[chan][k] = line_q[chan][k-1];
      end
      line_d[chan][0] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_d;
    end
  end

  // Tap 0 is the arriving sample; older taps come from the selected channel.
  assign taps[0] = din;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = line_q[chan][k-1];
  end

endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac #(
  parameter int                  NCH   = 3,
  parameter int                  NTAP  = 4,
  parameter int                  DW    = 8,
  parameter int                  CW    = 8,
  parameter int                  AW    = 18,
  parameter int                  CHW   = 2,
  parameter mcfir_pkg::fold_e    FOLD  = mcfir_pkg::TAPS_DIRECT,
  parameter logic [NCH*NTAP*CW-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    vld,
  input  logic [CHW-1:0]          chan,
  input  logic [NTAP-1:0][DW-1:0] taps,
  output logic                    s1_vld,
  output logic                    acc_vld,
  output logic [AW-1:0]           acc
);

  localparam bit FOLDED = (FOLD == mcfir_pkg::TAPS_EVEN_SYM);
  localparam int NMUL   = FOLDED ? (NTAP + 1) / 2 : NTAP;
  localparam int PW     = DW + 1 + CW;

  logic [NMUL-1:0][PW-1:0] prod_d;
  logic [NMUL-1:0][PW-1:0] prod_q;
  logic signed [AW-1:0]    sum_d;
  logic                    s1_en;
  logic                    s2_en;

  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic signed [DW:0]   op;
    logic signed [CW-1:0] cf;
    if (FOLDED && (2 * m != NTAP - 1)) begin : g_pair
      assign op = $signed({taps[m][DW-1], taps[m]})
                + $signed({taps[NTAP-1-m][DW-1], taps[NTAP-1-m]});
    end else begin : g_single
      assign op = $signed({taps[m][DW-1], taps[m]});
    end
    assign cf        = $signed(COEFS[(int'(chan) * NTAP + m) * CW +: CW]);
    assign prod_d[m] = PW'(op) * PW'(cf);
  end

  assign s1_en = vld | clr;
  assign s2_en = s1_vld | clr;

  always_comb begin
    sum_d = '0;
    for (int m = 0; m < NMUL; m++) begin
      sum_d = sum_d + AW'($signed(prod_q[m]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (s1_en) begin
      prod_q <= clr ? '0 : prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (s2_en) begin
      acc <= clr ? '0 : sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      acc_vld <= 1'b0;
    end else begin
      s1_vld  <= vld & ~clr;
      acc_vld <= s1_vld & ~clr;
    end
  end

endmodule

// File: rtl/mcfir_top.sv
module mcfir_top #(
  parameter int                     NCH     = 3,
  parameter int                     NTAP    = 4,
  parameter int                     DW      = 8,
  parameter int                     CW      = 8,
  parameter int                     OW      = 12,
  parameter int                     OUT_LSB = 4,
  parameter mcfir_pkg::fold_e       FOLD    = mcfir_pkg::TAPS_DIRECT,
  parameter logic [NCH*NTAP*CW-1:0] COEFS   = {(NCH * NTAP){CW'(1)}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_vld,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic [OW-1:0] out_dat
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int AW  = mcfir_pkg::acc_bits(DW, CW, NTAP);

  logic [CHW-1:0]          chan_q;
  logic                    accept;
  logic [NTAP-1:0][DW-1:0] taps;
  logic                    s1_vld;
  logic [AW-1:0]           acc_q;

  assign accept = in_vld & ~clr;

  mcfir_chan_ctr #(.NCH(NCH), .CHW(CHW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (accept),
    .chan  (chan_q)
  );

  mcfir_delay_bank #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CHW(CHW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (accept),
    .chan  (chan_q),
    .din   (in_dat),
    .taps  (taps)
  );

  mcfir_mac #(
    .NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW), .AW(AW), .CHW(CHW),
    .FOLD(FOLD), .COEFS(COEFS)
  ) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .vld     (accept),
    .chan    (chan_q),
    .taps    (taps),
    .s1_vld  (s1_vld),
    .acc_vld (out_vld),
    .acc     (acc_q)
  );

  assign out_dat = acc_q[OUT_LSB +: OW];

endmodule

// File: rtl/mcfir_chk.sv
module mcfir_chk #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic           in_vld,
  input logic           s1_vld,
  input logic           out_vld,
  input logic [CHW-1:0] chan
);

  AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !clr && chan == CHW'(NCH - 1)) |=> (chan == '0)); // R1

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !clr && chan != CHW'(NCH - 1)) |=> (chan == CHW'($past(chan) + CHW'(1)))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !clr) |=> ($stable(chan) && !s1_vld)); // R3

  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !clr) |=> s1_vld); // R4

  AST_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !clr) |=> out_vld); // R4

  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_vld); // R4

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_vld && !s1_vld && chan == '0)); // R6

endmodule

bind mcfir_top mcfir_chk #(.NCH(NCH), .CHW(CHW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr),
  .in_vld  (in_vld),
  .s1_vld  (s1_vld),
  .out_vld (out_vld),
  .chan    (chan_q)
);

// File: tb/mcfir_top_tb_top.sv
`timescale 1ns/1ps
module mcfir_top_tb_top;

  localparam int NCH = 3, NTAP = 4, DW = 8, CW = 8, OW = 12, LSB = 4;
  // Row ch, tap k at bits [(ch*NTAP+k)*CW +: CW].
  localparam logic [95:0] CF_A = {8'h00, 8'h01, 8'h80, 8'h7F,
                                  8'hFE, 8'h05, 8'h00, 8'hFF,
                                  8'h04, 8'h03, 8'h02, 8'h01};
  localparam logic [95:0] CF_B = {8'h07, 8'hFF, 8'hFF, 8'h07,
                                  8'hFD, 8'h05, 8'h05, 8'hFD,
                                  8'h01, 8'h02, 8'h02, 8'h01};
  // {tag[1:0], vld, clr, data}; tag 0:R1 1:R2 2:R3 3:R6
  localparam logic [11:0] VEC [0:23] = '{
    {2'd0,2'b10,8'h05}, {2'd0,2'b10,8'hFB}, {2'd0,2'b10,8'h10},
    {2'd0,2'b10,8'h03}, {2'd0,2'b10,8'h22}, {2'd0,2'b10,8'h81},
    {2'd2,2'b00,8'hAA}, {2'd2,2'b00,8'h55}, {2'd2,2'b10,8'h07},
    {2'd1,2'b10,8'h7F}, {2'd1,2'b10,8'hC0}, {2'd1,2'b10,8'h01},
    {2'd2,2'b00,8'hFF}, {2'd1,2'b10,8'hF0}, {2'd1,2'b10,8'h44},
    {2'd1,2'b10,8'h09}, {2'd1,2'b10,8'h80}, {2'd1,2'b10,8'h7E},
    {2'd3,2'b11,8'h33}, {2'd3,2'b10,8'h0A}, {2'd3,2'b10,8'h14},
    {2'd3,2'b10,8'h1E}, {2'd3,2'b10,8'hEC}, {2'd0,2'b00,8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          in_vld;
  logic [DW-1:0] in_dat;
  logic          out_vld, out_vld_b;
  logic [OW-1:0] out_dat, out_dat_b;

  int n_chk = 0;
  int n_err = 0;
  int ca [3][4] = '{'{1, 2, 3, 4}, '{-1, 0, 5, -2}, '{127, -128, 1, 0}};
  int cb [3][4] = '{'{1, 2, 2, 1}, '{-3, 5, 5, -3}, '{7, -1, -1, 7}};
  int ha [3][4];
  int hb [3][4];
  int chm;
  bit pv;
  logic [OW-1:0] pa, pb;
  string ptag;

  always #10 clk = ~clk;

  mcfir_top #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW), .OUT_LSB(LSB),
              .FOLD(mcfir_pkg::TAPS_DIRECT), .COEFS(CF_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_dat(in_dat),
    .out_vld(out_vld), .out_dat(out_dat));

  mcfir_top #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW), .OUT_LSB(LSB),
              .FOLD(mcfir_pkg::TAPS_EVEN_SYM), .COEFS(CF_B)) dut_sym_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_dat(in_dat),
    .out_vld(out_vld_b), .out_dat(out_dat_b));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R5: full sum in 18 bits, keep bits [15:4].
  function automatic logic [OW-1:0] slice(int acc);
    logic [17:0] a;
    a = acc[17:0];
    return a[LSB +: OW];
  endfunction

  function automatic int fir(int h [3][4], int c [3][4], int ch);
    int s = 0;
    for (int k = 0; k < 4; k++) s += h[ch][k] * c[ch][k];
    return s;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 4; k++) begin
        ha[c][k] = 0;
        hb[c][k] = 0;
      end
    chm = 0;
  endtask

  // One clock step: drive, advance model, check result of the previous step.
  task automatic step(bit v, bit c, logic [7:0] d, string tag);
    bit nv = 0;
    logic [OW-1:0] na = '0, nb = '0;
    @(negedge clk);
    in_vld = v; clr = c; in_dat = d;
    if (c) begin
      model_clear();
    end else if (v) begin
      for (int k = 3; k > 0; k--) begin
        ha[chm][k] = ha[chm][k-1];
        hb[chm][k] = hb[chm][k-1];
      end
      ha[chm][0] = int'($signed(d));
      hb[chm][0] = int'($signed(d));
      na = slice(fir(ha, ca, chm));
      nb = slice(fir(hb, cb, chm));
      nv = 1;
      chm = (chm + 1) % 3;
    end
    @(posedge clk);
    #1;
    if (c) pv = 0;
    chk(out_vld === pv, c ? "R6" : "R4", "out_vld", longint'(out_vld), longint'(pv));
    chk(out_vld_b === pv, c ? "R6" : "R4", "sym out_vld", longint'(out_vld_b), longint'(pv));
    if (pv) begin
      chk(out_dat === pa, ptag, "out_dat", longint'(out_dat), longint'(pa));
      chk(out_dat_b === pb, "R8", "sym out_dat", longint'(out_dat_b), longint'(pb));
    end
    pv = nv; pa = na; pb = nb; ptag = tag;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_vld = 1'b0; in_dat = '0;
    model_clear();
    pv = 0; pa = '0; pb = '0; ptag = "R1";
    repeat (3) @(posedge clk);
    #1;
    chk(out_vld === 1'b0, "R7", "reset out_vld", longint'(out_vld), 0);
    chk(out_dat === '0, "R7", "reset out_dat", longint'(out_dat), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1 rotation, R2 per-channel history, R3 gaps, R6 clear.
    for (int i = 0; i < 24; i++) begin
      logic [11:0] e;
      string t;
      e = VEC[i];
      case (e[11:10])
        2'd0: t = "R1";
        2'd1: t = "R2";
        2'd2: t = "R3";
        default: t = "R6";
      endcase
      step(e[9], e[8], e[7:0], t);
    end
    step(1'b0, 1'b0, 8'h00, "R4");

    // R5: extreme operands exercise full precision and the slice.
    step(1'b0, 1'b1, 8'h00, "R6");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 8'h80, "R5");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 8'h7F, "R5");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, (i % 2) ? 8'h80 : 8'h7F, "R5");

    // R6: clear one cycle after a sample drops it in flight.
    step(1'b1, 1'b0, 8'h11, "R6");
    step(1'b1, 1'b1, 8'h22, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'h30 + i), "R6");
    step(1'b0, 1'b0, 8'h00, "R6");

    // R7: asynchronous reset with a result on the output.
    step(1'b1, 1'b0, 8'h40, "R7");
    step(1'b1, 1'b0, 8'h50, "R7");
    @(negedge clk);
    in_vld = 1'b0;
    #3 rst_n = 1'b0;
    #2;
    chk(out_vld === 1'b0, "R7", "async out_vld", longint'(out_vld), 0);
    chk(out_dat === '0, "R7", "async out_dat", longint'(out_dat), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    pv = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'h61 - 3 * i), "R7");
    step(1'b0, 1'b0, 8'h00, "R4");
    step(1'b0, 1'b0, 8'h00, "R4");

    summary();
    $finish;
  end

endmodule